// File: doc/BRIEF.md
# Little-Endian Sized Memory Access Unit

This block connects a 64-bit processor data path to a byte-addressable store that is organised as rows of eight bytes. Each request carries a byte address, an access size (one, two, four or eight bytes), a read/write flag and 64 bits of write data. A write moves the low bytes of the operand into the byte lanes that its address selects and updates only those lanes of the addressed row. A read takes the selected lanes out of the row and returns them right-justified, with zeros above the requested size.

Values are stored least-significant byte first, at the start address. A request whose start address is not a whole multiple of its size is refused. It does not touch storage, it returns zero data, and it raises an error flag alongside its response. Every request is served as exactly one row access. A response follows each request one clock later. The store is modelled inside the block and is cleared to zero by reset.

Top module: `lsmem_unit`

## Requirements
- R1: An aligned write changes only the bytes from the start address up to start address plus size minus one. Every other byte of the row and of the store keeps its value.
- R2: Byte order is little-endian. Operand bits [7:0] go to the start address, bits [15:8] to the next address, and so on. A four-byte write of 0x12345678 at address 0 reads back, byte by byte, as 0x78, 0x56, 0x34, 0x12 at addresses 0 to 3.
- R3: The size code is 0 for one byte, 1 for two bytes, 2 for four bytes and 3 for eight bytes. A request is misaligned when its address is not a multiple of the size: a two-byte access on an odd address, a four-byte access with address bits [1:0] nonzero, or an eight-byte access with address bits [2:0] nonzero. `rspError` is 1 in the cycle after a misaligned request and 0 in the cycle after an aligned one.
- R4: A misaligned write leaves the whole store unchanged.
- R5: A misaligned read returns all-zero `rspRdata`.
- R6: An aligned read returns the bytes at the start address and the addresses above it in `rspRdata`, least-significant byte first, one cycle after the request. All bits above 8 times the size are zero.
- R7: `rspValid` is 1 in exactly the cycle after each request (`reqValid`=1) and 0 otherwise. `rspError` is never 1 while `rspValid` is 0.
- R8: The response to a write carries all-zero `rspRdata`.
- R9: After reset, `rspValid`, `rspError` and `rspRdata` are 0 and every byte of the store reads as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W (7) | Byte address; bits [2:0] select the lane, the upper bits select the row |
| reqSize | input | 2 | Size code: 0 = 1 byte, 1 = 2, 2 = 4, 3 = 8 |
| reqWdata | input | 64 | Write operand, right-justified |
| rspValid | output | 1 | Response for the request of the previous cycle |
| rspError | output | 1 | The previous request was misaligned |
| rspRdata | output | 64 | Right-justified, zero-filled read data |

## Verification
The hardest case to reach is an aligned access that sits at a nonzero lane offset inside a row that already holds unrelated bytes. Only this case shows whether the lane shift, the byte-enable window and the zero fill above the size work together. The stimulus forces about half of the random addresses onto the alignment of their size, which makes offsets 2, 4 and 6 with mixed sizes frequent. It also keeps a byte-exact model, so the neighbours of every write are checked by later wide reads. Directed requests fill the misaligned offsets for each size, and a full-row read after each of them shows that storage was left untouched.

// File: rtl/lsmem_pkg.sv
package lsmem_pkg;
  localparam int LANES  = 8;
  localparam int DATA_W = LANES * 8;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_WORD  = 2'd1,
    SZ_DWORD = 2'd2,
    SZ_QWORD = 2'd3
  } accSize_t;

  // strobes from control to datapath for the current request
  typedef struct packed {
    logic             wrEn;
    logic             rdEn;
    logic [LANES-1:0] byteEn;
    logic [2:0]       laneOff;
    accSize_t         sizeSel;
  } dpStrobe_t;
endpackage

// File: rtl/lsmem_ctrl.sv
module lsmem_ctrl
  import lsmem_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      reqWrite,
  input  logic [2:0] laneAddr,
  input  logic [1:0] reqSize,
  output dpStrobe_t strobe,
  output logic      rspValid,
  output logic      rspError
);
  logic [2:0] alignMask;
  logic       misaligned;
  logic [3:0] spanBytes;
  logic [LANES-1:0] laneHit;

  always_comb begin
    case (reqSize)
      2'd0:    begin alignMask = 3'b000; spanBytes = 4'd1; end
      2'd1:    begin alignMask = 3'b001; spanBytes = 4'd2; end
      2'd2:    begin alignMask = 3'b011; spanBytes = 4'd4; end
      default: begin alignMask = 3'b111; spanBytes = 4'd8; end
    endcase
    misaligned = |(laneAddr & alignMask);
  end

  for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
    localparam logic [3:0] LN = 4'(ln);
    assign laneHit[ln] = (LN >= {1'b0, laneAddr}) && (LN < ({1'b0, laneAddr} + spanBytes));
  end

  always_comb begin
    strobe.wrEn    = reqValid && reqWrite && !misaligned;
    strobe.rdEn    = reqValid && !reqWrite && !misaligned;
    strobe.byteEn  = misaligned ? '0 : laneHit;
    strobe.laneOff = laneAddr;
    strobe.sizeSel = accSize_t'(reqSize);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspError <= 1'b0;
    end else begin
      rspValid <= reqValid;
      rspError <= reqValid && misaligned;
    end
  end
endmodule

// File: rtl/lsmem_datapath.sv
module lsmem_datapath
  import lsmem_pkg::*;
#(
  parameter int ROW_BITS = 4,
  localparam int ROWS    = 1 << ROW_BITS
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpStrobe_t           strobe,
  input  logic [ROW_BITS-1:0] rowIdx,
  input  logic [DATA_W-1:0]   wrData,
  output logic [DATA_W-1:0]   rdData
);
  logic [DATA_W-1:0] memRows [ROWS];
  logic [DATA_W-1:0] rowCur;
  logic [DATA_W-1:0] wrShift;
  logic [DATA_W-1:0] rowNext;
  logic [DATA_W-1:0] rdShift;
  logic [DATA_W-1:0] rdMasked;
  logic [5:0]        bitOff;
  logic [3:0]        spanBytes;

  assign rowCur  = memRows[rowIdx];
  assign bitOff  = {strobe.laneOff, 3'b000};
  assign wrShift = wrData << bitOff;
  assign rdShift = rowCur >> bitOff;

  always_comb begin
    case (strobe.sizeSel)
      SZ_BYTE:  spanBytes = 4'd1;
      SZ_WORD:  spanBytes = 4'd2;
      SZ_DWORD: spanBytes = 4'd4;
      default:  spanBytes = 4'd8;
    endcase
  end

  for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
    localparam logic [3:0] LN = 4'(ln);
    assign rowNext[ln*8 +: 8]  = strobe.byteEn[ln] ? wrShift[ln*8 +: 8] : rowCur[ln*8 +: 8];
    assign rdMasked[ln*8 +: 8] = (LN < spanBytes) ? rdShift[ln*8 +: 8] : 8'h00;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int r = 0; r < ROWS; r++) memRows[r] <= '0;
    end else if (strobe.wrEn) begin
      memRows[rowIdx] <= rowNext;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) rdData <= '0;
    else       rdData <= strobe.rdEn ? rdMasked : '0;
  end
endmodule

// File: rtl/lsmem_unit.sv
module lsmem_unit
  import lsmem_pkg::*;
#(
  parameter int ROW_BITS = 4,
  parameter int ADDR_W   = ROW_BITS + 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqSize,
  input  logic [63:0]       reqWdata,
  output logic              rspValid,
  output logic              rspError,
  output logic [63:0]       rspRdata
);
  dpStrobe_t strobe;

  lsmem_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .laneAddr (reqAddr[2:0]),
    .reqSize  (reqSize),
    .strobe   (strobe),
    .rspValid (rspValid),
    .rspError (rspError)
  );

  lsmem_datapath #(.ROW_BITS(ROW_BITS)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .rowIdx (reqAddr[ADDR_W-1:3]),
    .wrData (reqWdata),
    .rdData (rspRdata)
  );
endmodule

// File: rtl/lsmem_checker.sv
module lsmem_checker #(
  parameter int ADDR_W = 7
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqWrite,
  input logic [ADDR_W-1:0] reqAddr,
  input logic [1:0]        reqSize,
  input logic              rspValid,
  input logic              rspError,
  input logic [63:0]       rspRdata
);
  logic offAligned;
  always_comb begin
    case (reqSize)
      2'd0:    offAligned = 1'b1;
      2'd1:    offAligned = (reqAddr[0] == 1'b0);
      2'd2:    offAligned = (reqAddr[1:0] == 2'b00);
      default: offAligned = (reqAddr[2:0] == 3'b000);
    endcase
  end

  AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);                                                   // R7
  AST_NO_RSP_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid);                                                 // R7
  AST_ERR_NEEDS_RSP: assert property (@(posedge clk) disable iff (!rstN)
    rspError |-> rspValid);                                                   // R7
  AST_MISALIGN_FLAGGED: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !offAligned) |=> rspError);                                  // R3
  AST_ALIGNED_CLEAN: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && offAligned) |=> !rspError);                                  // R3
  AST_ERR_ZERO_DATA: assert property (@(posedge clk) disable iff (!rstN)
    rspError |-> (rspRdata == 64'd0));                                        // R5
  AST_WRITE_ZERO_DATA: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqWrite) |=> (rspRdata == 64'd0));                          // R8
  AST_BYTE_ZERO_FILL: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqWrite && reqSize == 2'd0) |=> (rspRdata[63:8] == 56'd0)); // R6
  AST_WORD_ZERO_FILL: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqWrite && reqSize == 2'd1) |=> (rspRdata[63:16] == 48'd0)); // R6
endmodule

bind lsmem_unit lsmem_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .reqValid (reqValid),
  .reqWrite (reqWrite),
  .reqAddr  (reqAddr),
  .reqSize  (reqSize),
  .rspValid (rspValid),
  .rspError (rspError),
  .rspRdata (rspRdata)
);

// File: tb/sim_lsmem_unit.sv
module sim_lsmem_unit;
  localparam int CLK_PERIOD = 10;
  localparam int ROW_BITS   = 4;
  localparam int ADDR_W     = ROW_BITS + 3;
  localparam int NBYTES     = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              reqValid = 1'b0;
  logic              reqWrite = 1'b0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [1:0]        reqSize = '0;
  logic [63:0]       reqWdata = '0;
  logic              rspValid;
  logic              rspError;
  logic [63:0]       rspRdata;

  int checks = 0;
  int errors = 0;
  logic [7:0] model [NBYTES];

  always #(CLK_PERIOD/2) clk = ~clk;

  lsmem_unit #(.ROW_BITS(ROW_BITS)) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqSize(reqSize), .reqWdata(reqWdata),
    .rspValid(rspValid), .rspError(rspError), .rspRdata(rspRdata)
  );

  function automatic bit isAligned(int addr, int sz);
    return (addr % (1 << sz)) == 0;
  endfunction

  function automatic logic [63:0] expRead(int addr, int sz);
    logic [63:0] v = '0;
    for (int b = 0; b < (1 << sz); b++) v[b*8 +: 8] = model[addr + b];
    return v;
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one request; response sampled one cycle later, then an idle cycle
  task automatic access(bit wr, int addr, int sz, logic [63:0] wd, string req);
    bit ok;
    logic [63:0] expData;
    ok = isAligned(addr, sz);
    expData = (!wr && ok) ? expRead(addr, sz) : 64'd0;
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = ADDR_W'(addr);
    reqSize = 2'(sz); reqWdata = wd;
    @(posedge clk); #1;
    reqValid = 1'b0;
    if (wr && ok) for (int b = 0; b < (1 << sz); b++) model[addr + b] = wd[b*8 +: 8];
    check({req, " R7 rspValid"}, 64'(rspValid), 64'd1);
    check({req, " R3 rspError"}, 64'(rspError), 64'(!ok));
    if (wr) check({req, " R8 write data"}, rspRdata, 64'd0);
    else if (!ok) check({req, " R5 misaligned read"}, rspRdata, 64'd0);
    else check({req, " R6 read data"}, rspRdata, expData);
    @(posedge clk); #1;
    check({req, " R7 idle rspValid"}, 64'(rspValid), 64'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < NBYTES; i++) model[i] = 8'h00;
    repeat (3) @(posedge clk);
    #1;
    check("R9 reset rspValid", 64'(rspValid), 64'd0);
    check("R9 reset rspError", 64'(rspError), 64'd0);
    check("R9 reset rspRdata", rspRdata, 64'd0);
    @(negedge clk); rstN = 1'b1;
    access(0, 8, 3, 0, "R9 cleared row");
    access(0, NBYTES-8, 3, 0, "R9 cleared last row");

    // R2 little-endian layout
    access(1, 0, 2, 64'h12345678, "R2 dword write");
    access(0, 0, 0, 0, "R2 byte0");
    access(0, 1, 0, 0, "R2 byte1");
    access(0, 2, 0, 0, "R2 byte2");
    access(0, 3, 0, 0, "R2 byte3");
    check("R2 model byte3", 64'(model[3]), 64'h12);

    // R1 lane isolation inside a filled row
    access(1, 16, 3, 64'h8877665544332211, "R1 fill");
    access(1, 21, 0, 64'hFFFF_FFFF_FFFF_FFAB, "R1 byte write");
    access(0, 16, 3, 0, "R1 row readback");
    check("R1 lane value", expRead(16, 3), 64'h8877AB5544332211);
    access(1, 18, 1, 64'hCDEF, "R1 word write");
    access(0, 16, 3, 0, "R1 row after word");

    // R3/R4/R5 misaligned for every size and offset
    for (int sz = 1; sz < 4; sz++)
      for (int off = 1; off < 8; off++)
        if (off % (1 << sz) != 0) begin
          access(1, 24 + off, sz, 64'hDEAD_BEEF_CAFE_F00D, "R4 misaligned write");
          access(0, 24, 3, 0, "R4 row untouched");
          access(0, 16 + off, sz, 0, "R5 misaligned read");
        end

    // R6 random mix
    for (int n = 0; n < 500; n++) begin
      int sz = int'($urandom % 4);
      int addr = int'($urandom % NBYTES);
      bit wr = ($urandom % 2) == 1;
      logic [63:0] wd = {$urandom, $urandom};
      if ($urandom % 2) addr = addr & ~((1 << sz) - 1);
      access(wr, addr, sz, wd, "R6 random");
    end
    for (int r = 0; r < NBYTES; r += 8) access(0, r, 3, 0, "R1 final sweep");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule